// File: doc/BRIEF.md
# Queued SPI Master with Per-Entry Chip Select

This block is a serial master that runs a batch of full-duplex byte transfers from a sixteen-slot queue. Before a batch, software fills the queue through a small write port. Each slot holds a transmit byte and the chip-select code to drive while that byte is on the wire. Software then writes the number of transfers, and the batch starts as soon as an enable is present.

During the batch the block shifts each byte out on the data-out line and captures the data-in line into the same slot's receive byte. It reports progress through a four-bit completed-transfer pointer and a flag that tells "none done" apart from "all sixteen done". At the end it drops its busy flag and pulses an interrupt. Received bytes are then pulled one at a time through a read strobe, and each strobe moves a private read pointer.

A finished batch leaves the block locked until software writes the pointer-clear bit. Dropping both enables aborts any batch and returns every pointer to zero.

Top module: `qspi_fifo_master`

## Requirements
- R1: After reset: busy=0, irq=0, sck=1, mosi=1, cs_code=all ones (inactive), done_ptr=0, done_all=0, rx_data=0.
- R2: Bytes are sent and received MSB first. mosi changes only when sck falls, and miso is sampled when sck rises. sck idles high. Each sck low or high phase lasts floor(div/2) system clocks, where div is register 3, bits [7:0], reset value 4, and a value below 2 acts as 2.
- R3: While a slot is transferred, cs_code carries that slot's code, taken from write data bits [11:8]. Between two transfers of one batch, cs_code is all ones for exactly 2*floor(div/2) system clocks.
- R4: Writing register 1 sets the transfer count from bits [3:0], where 0 means 16. A batch transfers slots 0, 1, 2, … in order and then stops.
- R5: When the last transfer ends, busy falls and irq is 1 in that same cycle. irq lasts exactly one cycle, and there is one irq per batch.
- R6: done_ptr rises by one as each transfer ends. done_all becomes 1 only when sixteen transfers are done, and done_ptr then reads 0.
- R7: A one-cycle rx_re while unread bytes remain puts the next received byte on rx_data in the following cycle and advances the read pointer. With nothing unread, rx_data keeps its last value and the pointer stays put.
- R8: A write to register 1 while busy=1 is ignored, so the running batch keeps its original length.
- R9: After a batch has finished, no new batch starts until register 2 is written with bit 0 = 1. That write zeroes the load, read and completion pointers. It is ignored while busy=1.
- R10: A batch starts only while tx_en or rx_en is 1. When both fall to 0, one cycle later busy=0, sck=1, cs_code=all ones and done_ptr=0, and any pending count is discarded.
- R11: With tx_en=0 and rx_en=1, mosi is held at 1 for the whole transfer, and the received byte is still stored.
- R12: A write to register 0 stores {cs[11:8], data[7:0]} into the slot at the load pointer, then advances the pointer modulo 16, so a seventeenth load overwrites slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; when 0, mosi is held high |
| rx_en | input | 1 | Receive enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 load slot, 1 count, 2 control, 3 divider |
| cfg_wdata | input | 12 | Register write data |
| rx_re | input | 1 | Receive read strobe |
| rx_data | output | 8 | Last received byte read out |
| busy | output | 1 | Batch in progress |
| done_ptr | output | 4 | Completed transfers, modulo 16 |
| done_all | output | 1 | Sixteen transfers completed |
| irq | output | 1 | One-cycle end-of-batch pulse |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_code | output | 4 | Chip-select code, all ones when inactive |

## Verification
Two events can land in the same cycle: a read strobe and the completion of a transfer. The bench provokes this by holding rx_re high for a whole batch with distinct reply bytes. A strobe then arrives in every cycle, including the ones where done_ptr advances. The bench judges the result by the sequence of values that appears on rx_data: every reply must appear exactly once, in order, with none skipped or repeated. A second collision, a count write or a pointer clear landing while busy is high, is judged by the final done_ptr and by the number of slave transfers seen.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } eng_state_e;

    localparam logic [1:0] A_LOAD  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_DIV   = 2'd3;

endpackage

// File: rtl/qspi_entry_store.sv
module qspi_entry_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CSW   = 4,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [DW-1:0]   ld_data,
    input  logic [CSW-1:0]  ld_cs,
    input  logic [IDXW-1:0] tx_idx,
    output logic [DW-1:0]   tx_data,
    output logic [CSW-1:0]  tx_cs,
    input  logic            rx_we,
    input  logic [IDXW-1:0] rx_widx,
    input  logic [DW-1:0]   rx_wdata,
    input  logic [IDXW-1:0] rx_ridx,
    output logic [DW-1:0]   rx_rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0]  tx;
        logic [DEPTH-1:0][CSW-1:0] cs;
        logic [DEPTH-1:0][DW-1:0]  rx;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (ld_we && (ld_idx == IDXW'(i))) begin
                s_d.tx[i] = ld_data;
                s_d.cs[i] = ld_cs;
            end
            if (rx_we && (rx_widx == IDXW'(i))) begin
                s_d.rx[i] = rx_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_data  = s_q.tx[tx_idx];
    assign tx_cs    = s_q.cs[tx_idx];
    assign rx_rdata = s_q.rx[rx_ridx];

endmodule

// File: rtl/qspi_shift_engine.sv
module qspi_shift_engine
    import qspi_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CSW  = 4,
    parameter int DIVW = 8,
    localparam int BCW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [DIVW-1:0] half,
    input  logic            is_last,
    input  logic [DW-1:0]   tx_word,
    input  logic [CSW-1:0]  tx_cs,
    input  logic            miso,
    output logic            busy,
    output logic            sck,
    output logic            mosi_raw,
    output logic [CSW-1:0]  cs_out,
    output logic            xfer_end,
    output logic [DW-1:0]   rx_word,
    output logic            irq
);

    typedef struct packed {
        eng_state_e      st;
        logic [DIVW-1:0] timer;
        logic [BCW-1:0]  bitcnt;
        logic [DW-1:0]   txsh;
        logic [DW-1:0]   rxsh;
        logic            sck;
        logic            mosi;
        logic [CSW-1:0]  cs;
        logic            busy;
        logic            irq;
    } eng_t;

    eng_t r_d, r_q;
    logic tick;
    logic last_bit;

    assign tick     = (r_q.timer == '0);
    assign last_bit = (r_q.bitcnt == BCW'(DW - 1));
    assign xfer_end = !abort && (r_q.st == ST_HIGH) && tick && last_bit;

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (abort) begin
            r_d.st    = ST_IDLE;
            r_d.busy  = 1'b0;
            r_d.sck   = 1'b1;
            r_d.mosi  = 1'b1;
            r_d.cs    = '1;
            r_d.timer = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start) begin
                        r_d.st     = ST_SETUP;
                        r_d.busy   = 1'b1;
                        r_d.timer  = half - 1'b1;
                        r_d.cs     = tx_cs;
                        r_d.txsh   = tx_word;
                        r_d.bitcnt = '0;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        r_d.st    = ST_LOW;
                        r_d.sck   = 1'b0;
                        r_d.mosi  = r_q.txsh[DW-1];
                        r_d.txsh  = {r_q.txsh[DW-2:0], 1'b0};
                        r_d.timer = half - 1'b1;
                    end else begin
                        r_d.timer = r_q.timer - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        r_d.st    = ST_HIGH;
                        r_d.sck   = 1'b1;
                        r_d.rxsh  = {r_q.rxsh[DW-2:0], miso};
                        r_d.timer = half - 1'b1;
                    end else begin
                        r_d.timer = r_q.timer - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (last_bit) begin
                            r_d.cs = '1;
                            if (is_last) begin
                                r_d.st   = ST_IDLE;
                                r_d.busy = 1'b0;
                                r_d.irq  = 1'b1;
                            end else begin
                                r_d.st    = ST_GAP;
                                r_d.timer = DIVW'({half, 1'b0} - 1'b1);
                            end
                        end else begin
                            r_d.st     = ST_LOW;
                            r_d.bitcnt = r_q.bitcnt + 1'b1;
                            r_d.sck    = 1'b0;
                            r_d.mosi   = r_q.txsh[DW-1];
                            r_d.txsh   = {r_q.txsh[DW-2:0], 1'b0};
                            r_d.timer  = half - 1'b1;
                        end
                    end else begin
                        r_d.timer = r_q.timer - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        r_d.st     = ST_SETUP;
                        r_d.cs     = tx_cs;
                        r_d.txsh   = tx_word;
                        r_d.bitcnt = '0;
                        r_d.timer  = half - 1'b1;
                    end else begin
                        r_d.timer = r_q.timer - 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sck  <= 1'b1;
            r_q.mosi <= 1'b1;
            r_q.cs   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign sck      = r_q.sck;
    assign mosi_raw = r_q.mosi;
    assign cs_out   = r_q.cs;
    assign rx_word  = r_q.rxsh;
    assign irq      = r_q.irq;

endmodule

// File: rtl/qspi_queue_ctrl.sv
module qspi_queue_ctrl
    import qspi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CSW   = 4,
    parameter int DIVW  = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CNTW = IDXW + 1,
    localparam int CFGW = DW + CSW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [CFGW-1:0] cfg_wdata,
    input  logic            rx_re,
    input  logic            busy,
    input  logic            xfer_end,
    input  logic [DW-1:0]   rx_rdata,
    output logic            ld_we,
    output logic [IDXW-1:0] ld_idx,
    output logic [DW-1:0]   ld_data,
    output logic [CSW-1:0]  ld_cs,
    output logic            start,
    output logic            abort,
    output logic [DIVW-1:0] half,
    output logic            is_last,
    output logic [IDXW-1:0] idx,
    output logic            full,
    output logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rx_data
);

    typedef struct packed {
        logic [IDXW-1:0] wptr;
        logic [IDXW-1:0] sfp;
        logic            full;
        logic [CNTW-1:0] rdcnt;
        logic            armed;
        logic            needclr;
        logic [IDXW-1:0] cnt;
        logic [DIVW-1:0] div;
        logic            en;
        logic [DW-1:0]   rxd;
    } ctl_t;

    ctl_t c_d, c_q;

    logic            en;
    logic [CNTW-1:0] total;
    logic [CNTW-1:0] target;
    logic            rd_ok;
    logic            clr_req;

    assign en      = tx_en | rx_en;
    assign abort   = c_q.en & ~en;
    assign total   = {c_q.full, c_q.sfp};
    assign target  = (c_q.cnt == '0) ? CNTW'(DEPTH) : {1'b0, c_q.cnt};
    assign is_last = ((total + CNTW'(1)) == target);
    assign start   = c_q.armed && !c_q.needclr && !busy && en;
    assign rd_ok   = rx_re && (c_q.rdcnt < total);
    assign clr_req = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0] && !busy;

    assign ld_we   = cfg_we && (cfg_addr == A_LOAD);
    assign ld_idx  = c_q.wptr;
    assign ld_data = cfg_wdata[DW-1:0];
    assign ld_cs   = cfg_wdata[CFGW-1:DW];
    assign half    = (c_q.div < DIVW'(2)) ? DIVW'(1) : (c_q.div >> 1);

    always_comb begin
        c_d    = c_q;
        c_d.en = en;
        if (ld_we) c_d.wptr = c_q.wptr + 1'b1;
        if (start) c_d.armed = 1'b0;
        if (cfg_we && !busy) begin
            case (cfg_addr)
                A_COUNT: begin
                    c_d.cnt   = cfg_wdata[IDXW-1:0];
                    c_d.armed = 1'b1;
                end
                A_DIV:   c_d.div = cfg_wdata[DIVW-1:0];
                default: ;
            endcase
        end
        if (rd_ok) begin
            c_d.rxd   = rx_rdata;
            c_d.rdcnt = c_q.rdcnt + 1'b1;
        end
        if (xfer_end) begin
            c_d.sfp = c_q.sfp + 1'b1;
            if (c_q.sfp == IDXW'(DEPTH - 1)) c_d.full = 1'b1;
            if (is_last) c_d.needclr = 1'b1;
        end
        if (clr_req) begin
            c_d.wptr    = '0;
            c_d.sfp     = '0;
            c_d.full    = 1'b0;
            c_d.rdcnt   = '0;
            c_d.needclr = 1'b0;
        end
        if (abort) begin
            c_d.wptr    = '0;
            c_d.sfp     = '0;
            c_d.full    = 1'b0;
            c_d.rdcnt   = '0;
            c_d.armed   = 1'b0;
            c_d.needclr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.div <= DIVW'(4);
        end else begin
            c_q <= c_d;
        end
    end

    assign idx     = c_q.sfp;
    assign full    = c_q.full;
    assign rd_idx  = c_q.rdcnt[IDXW-1:0];
    assign rx_data = c_q.rxd;

endmodule

// File: rtl/qspi_fifo_master.sv
module qspi_fifo_master #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CSW   = 4,
    parameter int DIVW  = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CFGW = DW + CSW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [CFGW-1:0] cfg_wdata,
    input  logic            rx_re,
    output logic [DW-1:0]   rx_data,
    output logic            busy,
    output logic [IDXW-1:0] done_ptr,
    output logic            done_all,
    output logic            irq,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [CSW-1:0]  cs_code
);

    logic            ld_we;
    logic [IDXW-1:0] ld_idx;
    logic [DW-1:0]   ld_data;
    logic [CSW-1:0]  ld_cs;
    logic            start;
    logic            abort;
    logic [DIVW-1:0] half;
    logic            is_last;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] rd_idx;
    logic [DW-1:0]   tx_word;
    logic [CSW-1:0]  tx_cs;
    logic            xfer_end;
    logic [DW-1:0]   rx_word;
    logic [DW-1:0]   rx_rdata;
    logic            mosi_raw;

    qspi_queue_ctrl #(.DEPTH(DEPTH), .DW(DW), .CSW(CSW), .DIVW(DIVW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rx_re     (rx_re),
        .busy      (busy),
        .xfer_end  (xfer_end),
        .rx_rdata  (rx_rdata),
        .ld_we     (ld_we),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .ld_cs     (ld_cs),
        .start     (start),
        .abort     (abort),
        .half      (half),
        .is_last   (is_last),
        .idx       (idx),
        .full      (done_all),
        .rd_idx    (rd_idx),
        .rx_data   (rx_data)
    );

    qspi_entry_store #(.DEPTH(DEPTH), .DW(DW), .CSW(CSW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_idx   (ld_idx),
        .ld_data  (ld_data),
        .ld_cs    (ld_cs),
        .tx_idx   (idx),
        .tx_data  (tx_word),
        .tx_cs    (tx_cs),
        .rx_we    (xfer_end),
        .rx_widx  (idx),
        .rx_wdata (rx_word),
        .rx_ridx  (rd_idx),
        .rx_rdata (rx_rdata)
    );

    qspi_shift_engine #(.DW(DW), .CSW(CSW), .DIVW(DIVW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .half     (half),
        .is_last  (is_last),
        .tx_word  (tx_word),
        .tx_cs    (tx_cs),
        .miso     (miso),
        .busy     (busy),
        .sck      (sck),
        .mosi_raw (mosi_raw),
        .cs_out   (cs_code),
        .xfer_end (xfer_end),
        .rx_word  (rx_word),
        .irq      (irq)
    );

    assign done_ptr = idx;
    assign mosi     = tx_en ? mosi_raw : 1'b1;

endmodule

// File: rtl/qspi_fifo_master_chk.sv
module qspi_fifo_master_chk #(
    parameter int CSW  = 4,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_en,
    input logic            rx_en,
    input logic            busy,
    input logic            irq,
    input logic            sck,
    input logic [CSW-1:0]  cs_code,
    input logic [IDXW-1:0] done_ptr,
    input logic            done_all
);

    logic en;
    assign en = tx_en | rx_en;

    // R5
    irq_at_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R5
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3
    cs_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_code != '1) |-> busy);

    // R2
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // R6
    done_all_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_all |-> (done_ptr == '0));

    // R6
    done_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(done_ptr) |-> ((done_ptr == IDXW'($past(done_ptr) + 1'b1)) || (done_ptr == '0)));

    // R10
    enable_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> (!busy && (cs_code == '1) && (done_ptr == '0)));

endmodule

bind qspi_fifo_master qspi_fifo_master_chk #(.CSW(CSW), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .busy     (busy),
    .irq      (irq),
    .sck      (sck),
    .cs_code  (cs_code),
    .done_ptr (done_ptr),
    .done_all (done_all)
);

// File: tb/qspi_fifo_master_tb.sv
`timescale 1ns/1ps
module qspi_fifo_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        rx_re = 1'b0;
    logic [7:0]  rx_data;
    logic        busy, done_all, irq, sck, mosi;
    logic        miso = 1'b0;
    logic [3:0]  done_ptr, cs_code;

    int n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    qspi_fifo_master u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_re(rx_re), .rx_data(rx_data), .busy(busy), .done_ptr(done_ptr),
        .done_all(done_all), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_code(cs_code)
    );

    // slave model and timing monitor
    logic [7:0] resp [0:31];
    logic [7:0] cap_tx [0:31];
    logic [3:0] cap_cs [0:31];
    int s_idx, s_bit, irq_cnt, irq_wide, gap_run, gap_min, gap_max, low_run, low_min, low_max;

    task automatic mon_reset();
        s_idx = 0; s_bit = 0; irq_cnt = 0; irq_wide = 0;
        gap_run = 0; gap_min = 999; gap_max = 0;
        low_run = 0; low_min = 999; low_max = 0;
    endtask

    initial begin
        logic p_sck, p_irq;
        logic [3:0] p_cs;
        p_sck = 1'b1; p_irq = 1'b0; p_cs = 4'hF;
        mon_reset();
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
            if (irq && p_irq) irq_wide++;
            if (busy && cs_code == 4'hF) gap_run++;
            else if (gap_run > 0) begin
                if (gap_run < gap_min) gap_min = gap_run;
                if (gap_run > gap_max) gap_max = gap_run;
                gap_run = 0;
            end
            if (!sck) low_run++;
            else if (low_run > 0) begin
                if (low_run < low_min) low_min = low_run;
                if (low_run > low_max) low_max = low_run;
                low_run = 0;
            end
            if (cs_code != 4'hF && p_cs == 4'hF && s_idx < 32) begin
                cap_cs[s_idx] = cs_code;
                s_bit = 0;
            end
            if (cs_code != 4'hF && s_idx < 32) begin
                if (p_sck && !sck && s_bit < 8) miso = resp[s_idx][7 - s_bit];
                if (!p_sck && sck) begin
                    cap_tx[s_idx] = {cap_tx[s_idx][6:0], mosi};
                    s_bit++;
                end
            end
            if (cs_code == 4'hF && p_cs != 4'hF) s_idx++;
            p_sck = sck; p_irq = irq; p_cs = cs_code;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rx_re = 1'b1;
        @(negedge clk);
        rx_re = 1'b0;
        v = rx_data;
    endtask

    task automatic wait_batch(input string req, input int limit);
        int t;
        t = 0;
        while (!busy && t < 20) begin @(negedge clk); t++; end
        chk(req, int'(busy), 1);
        t = 0;
        while (busy && t < limit) begin @(negedge clk); t++; end
        chk(req, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 sck", int'(sck), 1);
        chk("R1 mosi", int'(mosi), 1);
        chk("R1 cs", int'(cs_code), 4'hF);
        chk("R1 done_ptr", int'(done_ptr), 0);
        chk("R1 done_all", int'(done_all), 0);
        chk("R1 rx_data", int'(rx_data), 0);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        tx_en = 1'b1; rx_en = 1'b1;
        wr(2, 12'h001);
        wr(3, 12'd4);
        wr(0, {4'hE, 8'hA5});
        wr(0, {4'hD, 8'h3C});
        wr(0, {4'hB, 8'hF0});
        resp[0] = 8'h5A; resp[1] = 8'hC3; resp[2] = 8'h81;
        mon_reset();
        wr(1, 12'd3);
        repeat (10) @(negedge clk);
        wr(1, 12'd7);                              // R8: ignored while busy
        wait_batch("R5 batch", 500);
        repeat (3) @(negedge clk);
        chk("R2 mosi byte0", int'(cap_tx[0]), 8'hA5);
        chk("R2 mosi byte1", int'(cap_tx[1]), 8'h3C);
        chk("R2 mosi byte2", int'(cap_tx[2]), 8'hF0);
        chk("R2 sck low phase", low_min, 2);
        chk("R2 sck low phase max", low_max, 2);
        chk("R3 cs slot0", int'(cap_cs[0]), 4'hE);
        chk("R3 cs slot1", int'(cap_cs[1]), 4'hD);
        chk("R3 cs slot2", int'(cap_cs[2]), 4'hB);
        chk("R3 gap min", gap_min, 4);
        chk("R3 gap max", gap_max, 4);
        chk("R8 transfer count", s_idx, 3);
        chk("R5 irq pulses", irq_cnt, 1);
        chk("R5 irq width", irq_wide, 0);
        chk("R6 done_ptr", int'(done_ptr), 3);
        chk("R6 done_all", int'(done_all), 0);
        for (int i = 0; i < 3; i++) begin
            rd(v);
            chk("R7 read", int'(v), int'(resp[i]));
        end
        rd(v);
        chk("R7 read when empty holds", int'(v), 8'h81);
    endtask

    task automatic t_noclear();
        wr(1, 12'd2);
        repeat (40) @(negedge clk);
        chk("R9 no start without clear", int'(busy), 0);
        chk("R9 done_ptr kept", int'(done_ptr), 3);
        resp[0] = 8'h11; resp[1] = 8'h22;
        mon_reset();
        wr(2, 12'h001);
        repeat (6) @(negedge clk);
        wr(2, 12'h001);                            // R9: ignored while busy
        wait_batch("R9 batch after clear", 500);
        chk("R9 transfers after clear", s_idx, 2);
        chk("R9 clear while busy ignored", int'(done_ptr), 2);
        chk("R9 slot1 data", int'(cap_tx[1]), 8'h3C);
    endtask

    task automatic t_full16();
        logic [7:0] v;
        wr(2, 12'h001);
        wr(3, 12'd2);
        for (int i = 0; i < 16; i++) begin
            wr(0, {4'(i % 15), 8'(i * 17 + 1)});
            resp[i] = ~8'(i * 17 + 1);
        end
        wr(0, {4'h7, 8'h99});                      // R12: wraps onto slot 0
        mon_reset();
        wr(1, 12'd0);
        wait_batch("R4 sixteen batch", 2000);
        chk("R4 count zero gives 16", s_idx, 16);
        chk("R12 wrapped slot0 data", int'(cap_tx[0]), 8'h99);
        chk("R12 wrapped slot0 cs", int'(cap_cs[0]), 4'h7);
        chk("R4 slot15 data", int'(cap_tx[15]), 8'(15 * 17 + 1));
        chk("R3 slot9 cs", int'(cap_cs[9]), 9);
        chk("R2 sck low phase div2", low_max, 1);
        chk("R6 done_ptr wraps", int'(done_ptr), 0);
        chk("R6 done_all set", int'(done_all), 1);
        for (int i = 0; i < 16; i++) begin
            rd(v);
            chk("R7 read sixteen", int'(v), int'(resp[i]));
        end
        rd(v);
        chk("R7 hold after sixteen", int'(v), int'(resp[15]));
    endtask

    task automatic t_rxonly();
        logic [7:0] v;
        wr(2, 12'h001);
        wr(3, 12'd6);
        tx_en = 1'b0;
        resp[0] = 8'h6B;
        mon_reset();
        wr(1, 12'd1);
        wait_batch("R11 rx-only batch", 500);
        chk("R11 mosi held high", int'(cap_tx[0]), 8'hFF);
        chk("R2 sck low phase div6", low_max, 3);
        rd(v);
        chk("R11 rx still stored", int'(v), 8'h6B);
        tx_en = 1'b1;
    endtask

    task automatic t_abort();
        int t;
        wr(2, 12'h001);
        wr(3, 12'd4);
        wr(1, 12'd2);
        repeat (12) @(negedge clk);
        chk("R10 running before drop", int'(busy), 1);
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        chk("R10 busy after drop", int'(busy), 0);
        chk("R10 cs after drop", int'(cs_code), 4'hF);
        chk("R10 sck after drop", int'(sck), 1);
        chk("R10 done_ptr after drop", int'(done_ptr), 0);
        wr(1, 12'd1);
        repeat (20) @(negedge clk);
        chk("R10 no start while disabled", int'(busy), 0);
        rx_en = 1'b1;
        t = 0;
        while (!busy && t < 10) begin @(negedge clk); t++; end
        chk("R10 start on enable", int'(busy), 1);
        tx_en = 1'b1;
        wait_batch("R10 batch", 500);
    endtask

    task automatic t_collide();
        logic [7:0] seen [0:7];
        logic [7:0] prev;
        int n, t;
        wr(2, 12'h001);
        resp[0] = 8'h4D; resp[1] = 8'h92; resp[2] = 8'h27;
        mon_reset();
        @(negedge clk);
        rx_re = 1'b1;
        prev = rx_data;
        n = 0;
        wr(1, 12'd3);
        t = 0;
        while ((busy || t < 8) && t < 1000) begin
            @(negedge clk);
            if (!busy) t++;
            if (rx_data != prev) begin
                if (n < 8) seen[n] = rx_data;
                n++;
                prev = rx_data;
            end
        end
        rx_re = 1'b0;
        chk("R7 reads alongside completions", n, 3);
        for (int i = 0; i < 3; i++)
            chk("R7 order with overlapping strobe", int'(seen[i]), int'(resp[i]));
        chk("R6 done_ptr after overlap", int'(done_ptr), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_noclear();
        t_full16();
        t_rxonly();
        t_abort();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule